// File: doc/BRIEF.md
# Inter-Core Interrupt Send Router

This block sits between a send-command write path and the per-core interrupt status banks of a multi-core cluster. A core that wants to interrupt another core writes a 32-bit command word. The command carries a destination core number and an interrupt vector number in fixed bit fields. The router decodes both fields and checks the destination against the number of cores present. For a valid destination, it drives a set request into that core's status bank: a single strobe, plus a data word with only the bit for the vector set.

A command whose destination lies beyond the last core is discarded. No status bank sees a write. Instead, a one-cycle error pulse is raised. All outputs are registered, so results appear one clock after the command is sampled. The router takes at most one command per cycle and never strobes more than one core at a time.

Top module: `ipi_send_router`

## Requirements
- R1: While reset is asserted, every set strobe, every set-data slice and the error pulse are zero, even if a command is presented.
- R2: The destination is command bits [25:16] (10 bits) and the vector is command bits [4:0] (5 bits). All other command bits have no effect on any output.
- R3: A command sampled with cmdValid high and destination below NUM_CORES raises setStrobe[destination] in the following cycle. No other strobe bit is raised.
- R4: In that cycle, setData slice [32*d+31:32*d] of the target core d equals 1 shifted left by the vector. Every other slice is zero.
- R5: A command whose destination is greater than or equal to NUM_CORES raises no strobe and writes zero on all data slices in the following cycle. This includes the boundary destination NUM_CORES and the maximum destination 1023.
- R6: dropPulse is high for exactly the cycle after each discarded command. It stays low after accepted commands.
- R7: A cycle with cmdValid low produces no strobe, all-zero set data and no error pulse in the next cycle.
- R8: Commands presented on consecutive cycles are each routed, or dropped, in their own next cycle, with no loss and no merging.
- R9: At most one setStrobe bit is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command word present this cycle |
| cmdData | input | 32 | Send command word |
| setStrobe | output | NUM_CORES | One-hot set request, one bit per core |
| setData | output | 32*NUM_CORES | Per-core set data, core d in slice [32*d+31:32*d] |
| dropPulse | output | 1 | One-cycle pulse for a discarded command |

## Verification
The hardest case to reach from the ports is a command stream that alternates between accepted and discarded commands with no idle cycle between them. Only then can a stale strobe, a stretched error pulse or leftover set data from the previous command show up. The bench drives such a stream on consecutive cycles and checks every output in each cycle. The stream includes the boundary destination equal to the core count and commands with junk in the unused bits. The bench then follows the stream with an idle cycle to confirm that everything returns to zero.

// File: rtl/ipi_router_pkg.sv
package ipi_router_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic accept;   // command routed to a core
    logic discard;  // command dropped, destination out of range
  } routeCtrl_t;
endpackage

// File: rtl/ipi_route_ctrl.sv
module ipi_route_ctrl
  import ipi_router_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int DEST_W    = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [DEST_W-1:0] destId,
  output routeCtrl_t        strobes,
  output logic              dropPulse
);
  localparam logic [DEST_W:0] CORE_LIMIT = (DEST_W+1)'(NUM_CORES);

  logic destInRange;

  always_comb begin
    destInRange     = ({1'b0, destId} < CORE_LIMIT);
    strobes.accept  = cmdValid && destInRange;
    strobes.discard = cmdValid && !destInRange;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dropPulse <= 1'b0;
    else       dropPulse <= strobes.discard;
  end
endmodule

// File: rtl/ipi_route_datapath.sv
module ipi_route_datapath
  import ipi_router_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int DEST_W    = 10,
  parameter int SET_W     = 32,
  localparam int VEC_W    = $clog2(SET_W)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  routeCtrl_t                 strobes,
  input  logic [DEST_W-1:0]          destId,
  input  logic [VEC_W-1:0]           vecId,
  output logic [NUM_CORES-1:0]       setStrobe,
  output logic [NUM_CORES*SET_W-1:0] setData
);
  logic [SET_W-1:0] vecOneHot;

  always_comb vecOneHot = SET_W'(1) << vecId;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic hit;
    always_comb hit = strobes.accept && (destId == DEST_W'(c));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        setStrobe[c]                <= 1'b0;
        setData[c*SET_W +: SET_W]   <= '0;
      end else begin
        setStrobe[c]                <= hit;
        setData[c*SET_W +: SET_W]   <= hit ? vecOneHot : '0;
      end
    end
  end
endmodule

// File: rtl/ipi_send_router.sv
module ipi_send_router
  import ipi_router_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int CMD_W     = 32,
  parameter int DEST_LSB  = 16,
  parameter int DEST_W    = 10,
  parameter int VEC_LSB   = 0,
  parameter int SET_W     = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cmdValid,
  input  logic [CMD_W-1:0]           cmdData,
  output logic [NUM_CORES-1:0]       setStrobe,
  output logic [NUM_CORES*SET_W-1:0] setData,
  output logic                       dropPulse
);
  localparam int VEC_W = $clog2(SET_W);
  localparam logic [CMD_W-1:0] FIELD_MASK =
      ((CMD_W'(1) << DEST_W) - CMD_W'(1)) << DEST_LSB |
      ((CMD_W'(1) << VEC_W)  - CMD_W'(1)) << VEC_LSB;

  logic [DEST_W-1:0] destId;
  logic [VEC_W-1:0]  vecId;
  logic              unusedCmdBits;
  routeCtrl_t        strobes;

  always_comb begin
    destId        = cmdData[DEST_LSB +: DEST_W];
    vecId         = cmdData[VEC_LSB +: VEC_W];
    unusedCmdBits = ^(cmdData & ~FIELD_MASK);
  end

  ipi_route_ctrl #(.NUM_CORES(NUM_CORES), .DEST_W(DEST_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .destId(destId),
    .strobes(strobes), .dropPulse(dropPulse)
  );

  ipi_route_datapath #(.NUM_CORES(NUM_CORES), .DEST_W(DEST_W), .SET_W(SET_W)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .destId(destId), .vecId(vecId),
    .setStrobe(setStrobe), .setData(setData)
  );
endmodule

// File: rtl/ipi_router_checker.sv
module ipi_router_checker #(
  parameter int NUM_CORES = 4
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    cmdValid,
  input logic [31:0]             cmdData,
  input logic [NUM_CORES-1:0]    setStrobe,
  input logic [NUM_CORES*32-1:0] setData,
  input logic                    dropPulse
);
  assert_onehot_strobe_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(setStrobe));

  assert_route_target_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && (int'(cmdData[25:16]) < NUM_CORES)) |=>
      (setStrobe == (NUM_CORES'(1) << $past(cmdData[25:16]))) && !dropPulse);

  assert_drop_out_of_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && (int'(cmdData[25:16]) >= NUM_CORES)) |=>
      (setStrobe == '0) && (setData == '0) && dropPulse);

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> (setStrobe == '0) && !dropPulse);

  assert_drop_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
    dropPulse |-> (setStrobe == '0));

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk
    assert_set_data_R4: assert property (@(posedge clk) disable iff (!rstN)
      (cmdValid && (int'(cmdData[25:16]) == c)) |=>
        (setData[c*32 +: 32] == (32'd1 << $past(cmdData[4:0]))));
    assert_idle_data_R4: assert property (@(posedge clk) disable iff (!rstN)
      !setStrobe[c] |-> (setData[c*32 +: 32] == '0));
  end
endmodule

bind ipi_send_router ipi_router_checker #(.NUM_CORES(NUM_CORES)) uChk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdData(cmdData),
  .setStrobe(setStrobe), .setData(setData), .dropPulse(dropPulse)
);

// File: tb/sim_ipi_send_router.sv
`timescale 1ns/1ps
module sim_ipi_send_router;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdValid = 1'b0;
  logic [31:0]   cmdData = '0;
  logic [NC-1:0] setStrobe;
  logic [NC*32-1:0] setData;
  logic          dropPulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  ipi_send_router #(.NUM_CORES(NC)) u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdData(cmdData),
    .setStrobe(setStrobe), .setData(setData), .dropPulse(dropPulse)
  );

  function automatic logic [31:0] mkCmd(int dest, int vec, logic [31:0] junk);
    logic [31:0] w;
    w = junk & ~32'h03FF_001F;
    w[25:16] = 10'(dest);
    w[4:0]   = 5'(vec);
    return w;
  endfunction

  task automatic cmp(string tag, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // expected outputs: dest<0 means no core written
  task automatic expectOut(string tag, int dest, int vec, bit drop);
    logic [NC-1:0]    eStb = '0;
    logic [NC*32-1:0] eDat = '0;
    if (dest >= 0 && dest < NC) begin
      eStb[dest] = 1'b1;
      eDat[dest*32 +: 32] = 32'd1 << vec;
    end
    cmp(tag, "setStrobe", 128'(setStrobe), 128'(eStb));
    cmp(tag, "setData", 128'(setData), 128'(eDat));
    cmp(tag, "dropPulse", 128'(dropPulse), 128'(drop));
    cmp({tag, "_R9"}, "strobe count<=1", 128'($countones(setStrobe) <= 1), 128'(1));
  endtask

  task automatic sendOne(string tag, logic [31:0] cmd, int dest, int vec, bit drop);
    @(negedge clk); cmdValid = 1'b1; cmdData = cmd;
    @(negedge clk); cmdValid = 1'b0; cmdData = '0;
    expectOut(tag, dest, vec, drop);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    @(negedge clk); cmdValid = 1'b1; cmdData = mkCmd(1, 7, '0);
    @(negedge clk);
    @(negedge clk);
    expectOut("R1_reset", -1, 0, 1'b0);
    cmdValid = 1'b0; cmdData = '0;
    rstN = 1'b1;
    @(negedge clk);
    expectOut("R1_after_release", -1, 0, 1'b0);
  endtask

  task automatic testAccept();
    sendOne("R3_core0_vec0", mkCmd(0, 0, '0), 0, 0, 1'b0);
    sendOne("R4_core3_vec31", mkCmd(3, 31, '0), 3, 31, 1'b0);
    sendOne("R3_core1_vec5", mkCmd(1, 5, '0), 1, 5, 1'b0);
    sendOne("R4_core2_vec16", mkCmd(2, 16, '0), 2, 16, 1'b0);
  endtask

  task automatic testFields();
    // junk in bits [31:26] and [15:5] must not matter
    sendOne("R2_junk_core2", mkCmd(2, 9, 32'hFFFF_FFFF), 2, 9, 1'b0);
    sendOne("R2_junk_core1", mkCmd(1, 30, 32'hA5A5_A5A5), 1, 30, 1'b0);
  endtask

  task automatic testDrop();
    sendOne("R5_dest_eq_cores", mkCmd(NC, 3, '0), -1, 0, 1'b1);
    @(negedge clk);
    expectOut("R6_drop_one_cycle", -1, 0, 1'b0);
    sendOne("R5_dest_max", mkCmd(1023, 31, 32'hFC00_FFE0), -1, 0, 1'b1);
    sendOne("R5_dest_64", mkCmd(64, 1, '0), -1, 0, 1'b1);
  endtask

  task automatic testIdle();
    @(negedge clk); cmdValid = 1'b0; cmdData = mkCmd(0, 4, '0);
    @(negedge clk);
    expectOut("R7_idle_with_data", -1, 0, 1'b0);
    cmdData = '0;
  endtask

  task automatic testBackToBack();
    @(negedge clk); cmdValid = 1'b1; cmdData = mkCmd(0, 1, '0);
    @(negedge clk); expectOut("R8_b2b_a", 0, 1, 1'b0);
    cmdData = mkCmd(NC, 2, '0);
    @(negedge clk); expectOut("R8_b2b_drop", -1, 0, 1'b1);
    cmdData = mkCmd(3, 12, 32'hFFFF_FFFF);
    @(negedge clk); expectOut("R6_b2b_after_drop", 3, 12, 1'b0);
    cmdData = mkCmd(5, 0, '0);
    @(negedge clk); expectOut("R8_b2b_drop2", -1, 0, 1'b1);
    cmdData = mkCmd(5, 0, '0);
    @(negedge clk); expectOut("R6_b2b_drop_repeat", -1, 0, 1'b1);
    cmdData = mkCmd(2, 27, '0);
    @(negedge clk); expectOut("R8_b2b_c", 2, 27, 1'b0);
    cmdData = mkCmd(2, 3, '0);
    @(negedge clk); expectOut("R8_b2b_same_core", 2, 3, 1'b0);
    cmdValid = 1'b0; cmdData = '0;
    @(negedge clk); expectOut("R7_b2b_idle", -1, 0, 1'b0);
  endtask

  initial begin
    testReset();
    testAccept();
    testFields();
    testDrop();
    testIdle();
    testBackToBack();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule